// File: doc/BRIEF.md
# Special-Register Access Controller

This block sits beside a CPU's execute stage and handles its move-to-special-register and move-from-special-register requests. Each request carries a read or write strobe, a 16-bit register number, write data and the two privilege bits taken from the status register. The controller checks privilege, decodes the register number and then does one of four things. It returns read data, raises a write enable for one register held elsewhere in the core, asks the fetch unit to restart at a new program counter, or flags a warning with a reason code.

The block owns a bank of general-purpose shadow registers that can be reached through a window in the same register number space. The other special registers live outside. The controller sees their current values on a packed read bus and drives their write enables. What those registers do is not the controller's concern.

All results are registered. Every request produces its complete outcome in the cycle after it is presented, and every output is a single-cycle pulse.

Top module: `sreg_access_ctrl`

## Requirements
- R1: A request is carried out only when `priv_super` or `priv_user_sreg` is 1; either bit alone is enough. When both are 0, any read or write gives `warn`=1 with `warn_code`=1, `rd_data`=0 and no write enable, no redirect and no change to a shadow register.
- R2: These registers are readable, and each returns a 32-bit slot of `ext_rdata` (slot i occupies bits [32*i+31:32*i]):
  - version 0x0000 → slot 0
  - unit map 0x0001 → slot 1
  - core config 0x0002 → slot 2
  - status 0x0011 → slot 3
  - previous PC 0x0012 → slot 4
  - float status 0x0014 → slot 5
  - exception PC 0x0020 → slot 6
  - accumulator low 0x2801 → slot 7
  - accumulator high 0x2802 → slot 8
- R3: Register numbers 0x0400 to 0x05FF form a window onto 512 shadow registers (index = number − 0x0400). A privileged write stores the data, and a later read at the same number returns it.
- R4: A privileged write to a writable register raises exactly one bit of `wr_en`, with `wr_data` equal to the written value. The writable registers and their bits are:
  - status 0x0011 → bit 0
  - float status 0x0014 → bit 1
  - exception PC 0x0020 → bit 2
  - saved status 0x0030 → bit 3
  - accumulator low 0x2801 → bit 4
  - accumulator high 0x2802 → bit 5
- R5: A privileged write to next-PC (0x0010) gives `redirect_valid`=1 with `redirect_pc` equal to the written value. No write enable and no warning accompany it.
- R6: A privileged write to the timer mode register (0x5000) whose value is zero raises `wr_en` bit 6 with no warning. Any non-zero value gives `warn_code`=3 and no write enable.
- R7: Any other privileged access gives `warn_code`=2, `rd_data`=0 and no side effect. This covers reads of 0x0010, 0x0030 and 0x5000, writes to read-only registers, and the numbers 0x03FF and 0x0600 just outside the window.
- R8: Each request's results appear in the cycle after it is presented and last one cycle. `rd_valid` pulses for every read, accepted or not. With no request, all outputs are 0, and this is also their state after reset.
- R9: When both strobes are high, the request is a read and the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | 16 | Register number |
| req_wdata | input | 32 | Write data |
| priv_super | input | 1 | Supervisor bit from status |
| priv_user_sreg | input | 1 | User special-register access bit from status |
| ext_rdata | input | 288 | Current values of the nine readable external registers, 32 bits per slot |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 32 | Read result, 0 when rejected |
| wr_en | output | 7 | One-hot write enable per external register |
| wr_data | output | 32 | Data for the enabled register |
| redirect_valid | output | 1 | Restart fetch request |
| redirect_pc | output | 32 | Restart address |
| warn | output | 1 | Warning pulse |
| warn_code | output | 2 | 0 none, 1 privilege, 2 bad address, 3 bad value |

## Verification
Every result of a request, whether read data, write enable, redirect or warning, is due exactly one clock edge after the request is driven. This includes shadow-register reads, whose bank read is synchronous. The driver applies a request on a falling edge and queues the full expected output set for it. Idle cycles queue an all-zero set. The monitor pops one entry shortly after each rising edge and compares all outputs at once, so a result that arrives early, late or lasts two cycles disagrees with its neighbours' entries. Shadow-register contents are tracked by a model array in the bench, kept apart from the design.

// File: rtl/sprc_pkg.sv
package sprc_pkg;

    localparam int DW   = 32;
    localparam int AW   = 16;
    localparam int N_RD = 9;
    localparam int N_WE = 7;

    localparam logic [AW-1:0] A_VERSION = 16'h0000;
    localparam logic [AW-1:0] A_UNITS   = 16'h0001;
    localparam logic [AW-1:0] A_CORECFG = 16'h0002;
    localparam logic [AW-1:0] A_NEXTPC  = 16'h0010;
    localparam logic [AW-1:0] A_STATUS  = 16'h0011;
    localparam logic [AW-1:0] A_PREVPC  = 16'h0012;
    localparam logic [AW-1:0] A_FSTAT   = 16'h0014;
    localparam logic [AW-1:0] A_EXCPC   = 16'h0020;
    localparam logic [AW-1:0] A_EXCSR   = 16'h0030;
    localparam logic [AW-1:0] A_ACCLO   = 16'h2801;
    localparam logic [AW-1:0] A_ACCHI   = 16'h2802;
    localparam logic [AW-1:0] A_TMODE   = 16'h5000;

    localparam int WE_TMODE = 6;

    typedef enum logic [1:0] {
        WARN_NONE  = 2'd0,
        WARN_PRIV  = 2'd1,
        WARN_ADDR  = 2'd2,
        WARN_VALUE = 2'd3
    } warn_e;

    typedef struct packed {
        logic            rd_ok;
        logic [3:0]      rd_slot;
        logic            gpr_rd;
        logic            gpr_we;
        logic [N_WE-1:0] we;
        logic            redirect;
        warn_e           warn;
    } dec_t;

    // read-bus slot for an external register, -1 when not readable
    function automatic int rd_slot_of(logic [AW-1:0] a);
        case (a)
            A_VERSION: return 0;
            A_UNITS:   return 1;
            A_CORECFG: return 2;
            A_STATUS:  return 3;
            A_PREVPC:  return 4;
            A_FSTAT:   return 5;
            A_EXCPC:   return 6;
            A_ACCLO:   return 7;
            A_ACCHI:   return 8;
            default:   return -1;
        endcase
    endfunction

    // write-enable bit for a plain writable register, -1 when none
    function automatic int we_bit_of(logic [AW-1:0] a);
        case (a)
            A_STATUS: return 0;
            A_FSTAT:  return 1;
            A_EXCPC:  return 2;
            A_EXCSR:  return 3;
            A_ACCLO:  return 4;
            A_ACCHI:  return 5;
            default:  return -1;
        endcase
    endfunction

endpackage

// File: rtl/sprc_decode.sv
module sprc_decode
    import sprc_pkg::*;
#(
    parameter int GPR_BASE  = 16'h0400,
    parameter int GPR_COUNT = 512,
    localparam int IW       = $clog2(GPR_COUNT)
) (
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          priv_a,
    input  logic          priv_b,
    output dec_t          dec,
    output logic [IW-1:0] gpr_idx
);

    logic in_window;
    logic is_rd;
    logic is_wr;

    assign in_window = ({1'b0, addr} >= 17'(GPR_BASE)) &&
                       ({1'b0, addr} <  17'(GPR_BASE + GPR_COUNT));
    assign gpr_idx   = IW'(addr - AW'(GPR_BASE));
    assign is_rd     = rd;
    assign is_wr     = wr & ~rd;   // read wins when both strobes are set

    always_comb begin
        int slot;
        int wbit;
        slot = rd_slot_of(addr);
        wbit = we_bit_of(addr);
        dec  = '0;
        dec.warn = WARN_NONE;
        if (is_rd || is_wr) begin
            if (!(priv_a || priv_b)) begin
                dec.warn = WARN_PRIV;
            end else if (in_window) begin
                dec.gpr_rd = is_rd;
                dec.gpr_we = is_wr;
            end else if (is_rd) begin
                if (slot >= 0) begin
                    dec.rd_ok   = 1'b1;
                    dec.rd_slot = 4'(slot);
                end else begin
                    dec.warn = WARN_ADDR;
                end
            end else if (addr == A_NEXTPC) begin
                dec.redirect = 1'b1;
            end else if (addr == A_TMODE) begin
                if (wdata == '0) dec.we[WE_TMODE] = 1'b1;
                else             dec.warn = WARN_VALUE;
            end else if (wbit >= 0) begin
                dec.we[wbit] = 1'b1;
            end else begin
                dec.warn = WARN_ADDR;
            end
        end
    end

endmodule

// File: rtl/sprc_gpr_bank.sv
module sprc_gpr_bank #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [IW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wdata;
        if (rd_en) rdata    <= mem[idx];
    end

endmodule

// File: rtl/sreg_access_ctrl.sv
module sreg_access_ctrl
    import sprc_pkg::*;
#(
    parameter int GPR_BASE  = 16'h0400,
    parameter int GPR_COUNT = 512,
    localparam int IW       = $clog2(GPR_COUNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_rd,
    input  logic               req_wr,
    input  logic [15:0]        req_addr,
    input  logic [31:0]        req_wdata,
    input  logic               priv_super,
    input  logic               priv_user_sreg,
    input  logic [N_RD*DW-1:0] ext_rdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic [N_WE-1:0]    wr_en,
    output logic [31:0]        wr_data,
    output logic               redirect_valid,
    output logic [31:0]        redirect_pc,
    output logic               warn,
    output logic [1:0]         warn_code
);

    dec_t          dec;
    logic [IW-1:0] gpr_idx;
    logic [DW-1:0] bank_q;
    logic [DW-1:0] ext_q;
    logic          from_gpr_q;
    warn_e         warn_q;

    sprc_decode #(.GPR_BASE(GPR_BASE), .GPR_COUNT(GPR_COUNT)) u_dec (
        .rd      (req_rd),
        .wr      (req_wr),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .priv_a  (priv_super),
        .priv_b  (priv_user_sreg),
        .dec     (dec),
        .gpr_idx (gpr_idx)
    );

    sprc_gpr_bank #(.DEPTH(GPR_COUNT), .WIDTH(DW)) u_bank (
        .clk   (clk),
        .rd_en (dec.gpr_rd),
        .wr_en (dec.gpr_we),
        .idx   (gpr_idx),
        .wdata (req_wdata),
        .rdata (bank_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid       <= 1'b0;
            from_gpr_q     <= 1'b0;
            ext_q          <= '0;
            wr_en          <= '0;
            wr_data        <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            warn_q         <= WARN_NONE;
        end else begin
            rd_valid       <= req_rd;
            from_gpr_q     <= dec.gpr_rd;
            ext_q          <= dec.rd_ok ? ext_rdata[dec.rd_slot*DW +: DW] : '0;
            wr_en          <= dec.we;
            wr_data        <= (|dec.we) ? req_wdata : '0;
            redirect_valid <= dec.redirect;
            redirect_pc    <= dec.redirect ? req_wdata : '0;
            warn_q         <= dec.warn;
        end
    end

    assign rd_data   = from_gpr_q ? bank_q : ext_q;
    assign warn      = (warn_q != WARN_NONE);
    assign warn_code = warn_q;

    AST_NO_ACT_WITHOUT_PRIV: assert property (@(posedge clk) disable iff (rst)
        ((|wr_en) || redirect_valid) |-> $past(priv_super || priv_user_sreg)); // R1
    AST_GPR_WR_PRIV: assert property (@(posedge clk) disable iff (rst)
        dec.gpr_we |-> (priv_super || priv_user_sreg)); // R1
    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en)); // R4
    AST_WE_DATA: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> (wr_data == $past(req_wdata))); // R4
    AST_REDIRECT_PC: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_pc == $past(req_wdata) && !warn && wr_en == '0)); // R5
    AST_WARN_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        warn |-> (wr_en == '0 && !redirect_valid && rd_data == '0)); // R7
    AST_RESULT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        (rd_valid || warn || redirect_valid || (|wr_en)) |-> $past(req_rd || req_wr)); // R8
    AST_BOTH_IS_READ: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_wr) |=> (wr_en == '0 && !redirect_valid && rd_valid)); // R9

endmodule

// File: tb/sim_sreg_access_ctrl.sv
`timescale 1ns/1ps
module sim_sreg_access_ctrl;

    typedef struct {
        logic        rv;
        logic [31:0] rd;
        logic [6:0]  we;
        logic [31:0] wd;
        logic        rdr;
        logic [31:0] pc;
        logic        w;
        logic [1:0]  wc;
        string       tag;
    } exp_t;

    logic         clk = 0;
    logic         rst = 1;
    logic         req_rd = 0, req_wr = 0;
    logic [15:0]  req_addr = 0;
    logic [31:0]  req_wdata = 0;
    logic         priv_super = 0, priv_user_sreg = 0;
    logic [287:0] ext_rdata;
    logic         rd_valid, redirect_valid, warn;
    logic [31:0]  rd_data, wr_data, redirect_pc;
    logic [6:0]   wr_en;
    logic [1:0]   warn_code;

    int checks = 0, failures = 0;
    exp_t q[$];
    logic [31:0] gm [512];
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] ext_val(int i);
        return 32'hA500_0000 + 32'(i) * 32'h0101_0011;
    endfunction

    initial for (int i = 0; i < 9; i++) ext_rdata[i*32 +: 32] = ext_val(i);

    sreg_access_ctrl u0 (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .priv_super(priv_super), .priv_user_sreg(priv_user_sreg),
        .ext_rdata(ext_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .warn(warn), .warn_code(warn_code)
    );

    // expected outcome from the requirement text
    function automatic exp_t model(bit rd, bit wr, logic [15:0] a, logic [31:0] d,
                                   bit sup, bit usr, string tag);
        exp_t e;
        int slot, wb;
        e.rv = rd; e.rd = 0; e.we = 0; e.wd = 0; e.rdr = 0; e.pc = 0;
        e.w = 0; e.wc = 0; e.tag = tag;
        if (!rd && !wr) return e;
        if (!(sup || usr)) begin e.w = 1; e.wc = 1; return e; end
        if (a >= 16'h0400 && a <= 16'h05FF) begin
            if (rd) e.rd = gm[a - 16'h0400];
            else    gm[a - 16'h0400] = d;
            return e;
        end
        case (a)
            16'h0000: slot = 0; 16'h0001: slot = 1; 16'h0002: slot = 2;
            16'h0011: slot = 3; 16'h0012: slot = 4; 16'h0014: slot = 5;
            16'h0020: slot = 6; 16'h2801: slot = 7; 16'h2802: slot = 8;
            default:  slot = -1;
        endcase
        case (a)
            16'h0011: wb = 0; 16'h0014: wb = 1; 16'h0020: wb = 2;
            16'h0030: wb = 3; 16'h2801: wb = 4; 16'h2802: wb = 5;
            default:  wb = -1;
        endcase
        if (rd) begin
            if (slot >= 0) e.rd = ext_val(slot);
            else begin e.w = 1; e.wc = 2; end
        end else if (a == 16'h0010) begin
            e.rdr = 1; e.pc = d;
        end else if (a == 16'h5000) begin
            if (d == 0) e.we[6] = 1;
            else begin e.w = 1; e.wc = 3; end
        end else if (wb >= 0) begin
            e.we[wb] = 1; e.wd = d;
        end else begin
            e.w = 1; e.wc = 2;
        end
        return e;
    endfunction

    task automatic op(bit rd, bit wr, logic [15:0] a, logic [31:0] d,
                      bit sup, bit usr, string tag);
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d;
        priv_super = sup; priv_user_sreg = usr;
        q.push_back(model(rd, wr, a, d, sup, usr, tag));
    endtask

    task automatic idle(string tag);
        op(0, 0, 16'h0000, 32'h0, 1, 0, tag);
    endtask

    // monitor: one expected item per cycle, sampled after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rd_valid !== e.rv || rd_data !== e.rd || wr_en !== e.we ||
                    wr_data !== e.wd || redirect_valid !== e.rdr ||
                    redirect_pc !== e.pc || warn !== e.w || warn_code !== e.wc) begin
                    failures++;
                    $display("FAIL %s: got rv=%0b rd=%h we=%b wd=%h rdr=%0b pc=%h w=%0b wc=%0d exp rv=%0b rd=%h we=%b wd=%h rdr=%0b pc=%h w=%0b wc=%0d",
                             e.tag, rd_valid, rd_data, wr_en, wr_data, redirect_valid,
                             redirect_pc, warn, warn_code, e.rv, e.rd, e.we, e.wd,
                             e.rdr, e.pc, e.w, e.wc);
                end
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) gm[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        checks++;
        if (rd_valid !== 0 || wr_en !== 0 || redirect_valid !== 0 || warn !== 0 || rd_data !== 0) begin
            failures++;
            $display("FAIL R8 reset: got rv=%0b we=%b rdr=%0b w=%0b rd=%h exp all zero",
                     rd_valid, wr_en, redirect_valid, warn, rd_data);
        end
        // R2 every readable register
        op(1, 0, 16'h0000, 0, 1, 0, "R2 version");
        op(1, 0, 16'h0001, 0, 1, 0, "R2 units");
        op(1, 0, 16'h0002, 0, 1, 0, "R2 corecfg");
        op(1, 0, 16'h0011, 0, 1, 0, "R2 status");
        op(1, 0, 16'h0012, 0, 1, 0, "R2 prevpc");
        op(1, 0, 16'h0014, 0, 1, 0, "R2 fstat");
        op(1, 0, 16'h0020, 0, 1, 0, "R2 excpc");
        op(1, 0, 16'h2801, 0, 1, 0, "R2 acclo");
        op(1, 0, 16'h2802, 0, 1, 0, "R2 acchi");
        idle("R8 idle");
        // R4 each writable register
        op(0, 1, 16'h0011, 32'h1111_0001, 1, 0, "R4 status");
        op(0, 1, 16'h0014, 32'h2222_0002, 1, 0, "R4 fstat");
        op(0, 1, 16'h0020, 32'h3333_0003, 1, 0, "R4 excpc");
        op(0, 1, 16'h0030, 32'h4444_0004, 0, 1, "R4 excsr");
        op(0, 1, 16'h2801, 32'h5555_0005, 1, 0, "R4 acclo");
        op(0, 1, 16'h2802, 32'h6666_0006, 1, 1, "R4 acchi");
        // R3 window edges and middle
        op(0, 1, 16'h0400, 32'hDEAD_0000, 1, 0, "R3 wr first");
        op(0, 1, 16'h05FF, 32'hDEAD_01FF, 1, 0, "R3 wr last");
        op(0, 1, 16'h0464, 32'hCAFE_0064, 0, 1, "R3 wr mid");
        op(1, 0, 16'h05FF, 0, 1, 0, "R3 rd last");
        op(1, 0, 16'h0400, 0, 1, 0, "R3 rd first");
        op(1, 0, 16'h0464, 0, 0, 1, "R3 rd mid");
        // R5 redirect
        op(0, 1, 16'h0010, 32'h0000_2000, 1, 0, "R5 nextpc");
        idle("R8 idle after redirect");
        // R6 timer mode
        op(0, 1, 16'h5000, 32'h0, 1, 0, "R6 tmode zero");
        op(0, 1, 16'h5000, 32'h0000_0010, 1, 0, "R6 tmode nonzero");
        // R7 invalid numbers
        op(1, 0, 16'h0030, 0, 1, 0, "R7 rd excsr");
        op(1, 0, 16'h0010, 0, 1, 0, "R7 rd nextpc");
        op(1, 0, 16'h5000, 0, 1, 0, "R7 rd tmode");
        op(0, 1, 16'h0000, 32'h1, 1, 0, "R7 wr version");
        op(1, 0, 16'h03FF, 0, 1, 0, "R7 below window");
        op(0, 1, 16'h0600, 32'h9, 1, 0, "R7 above window");
        op(1, 0, 16'h7777, 0, 1, 0, "R7 unknown");
        // R1 privilege
        op(0, 1, 16'h0405, 32'h0BAD_0005, 1, 0, "R3 wr gpr5");
        op(1, 0, 16'h0000, 0, 0, 0, "R1 rd denied");
        op(0, 1, 16'h0011, 32'h5, 0, 0, "R1 wr denied");
        op(0, 1, 16'h0010, 32'h5, 0, 0, "R1 redirect denied");
        op(0, 1, 16'h0405, 32'hFFFF_FFFF, 0, 0, "R1 gpr wr denied");
        op(1, 0, 16'h0405, 0, 1, 0, "R1 gpr unchanged");
        op(1, 0, 16'h0011, 0, 0, 1, "R1 user bit alone");
        // R9 both strobes
        op(0, 1, 16'h0407, 32'h7777_0007, 1, 0, "R3 wr gpr7");
        op(1, 1, 16'h0407, 32'h1234_5678, 1, 0, "R9 both on gpr");
        op(1, 0, 16'h0407, 0, 1, 0, "R9 gpr7 kept");
        op(1, 1, 16'h0011, 32'h1, 1, 0, "R9 both on status");
        idle("R8 final idle");
        idle("R8 final idle");
        @(negedge clk);
        req_rd = 0; req_wr = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule